// File: doc/BRIEF.md
# SPI Burst Register Port

This block is a four-wire SPI slave that lets an external controller read and write a 64-entry register file of 8-bit words. SCK, MOSI and the active-low select are brought into the system clock through synchronisers, and all decoding runs on the system clock. The register file sits outside the block. It sees an address, write data, a one-cycle write strobe and a combinational read-data return.

A transaction starts when select goes low. The first byte is a command. It carries a direction flag, an auto-increment flag and a start address. Any number of data bytes may follow, and the transaction ends when select goes high. With auto-increment set, each data byte moves to the next address, and the address wraps from 63 back to 0. With auto-increment clear, every data byte uses the start address. The port runs in SPI mode 0 and sends the MSB first.

Top module: `spi_burst_port`

## Requirements
- R1: After select falls, the first 8 bits received form the command byte. Bit 7 = 1 means write and 0 means read. Bit 6 = 1 turns on address auto-increment. Bits 5:0 give the start address.
- R2: Mode 0, MSB first. MOSI is sampled on the rising SCK edge. MISO changes only after a falling SCK edge.
- R3: In a write transaction, each complete data byte produces exactly one reg_we_o pulse, one system-clock cycle wide. reg_wdata_o carries the received byte and reg_addr_o carries the target address.
- R4: With auto-increment set, the address advances by one after each data byte, and the step after 63 goes to 0.
- R5: With auto-increment clear, every data byte of the burst uses the start address.
- R6: In a read transaction, the word at the current address is captured at each byte boundary and shifted out MSB first during the next data byte.
- R7: Bursts have no length limit. Raising select ends the transaction, and the next falling select expects a new command byte.
- R8: A byte that is only partly shifted in when select rises is dropped and produces no write strobe.
- R9: MISO is 0 while select is high, during the command byte and throughout write transactions.
- R10: After reset, miso_o = 0, reg_we_o = 0 and reg_addr_o = 0.
- R11: No write strobe is produced during a read transaction or during a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock, idle low |
| mosi_i | input | 1 | Serial data from the controller |
| ss_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data to the controller |
| reg_addr_o | output | 6 | Register file address |
| reg_wdata_o | output | 8 | Register file write data |
| reg_we_o | output | 1 | Register file write strobe, one cycle |
| reg_rdata_i | input | 8 | Register file read data for reg_addr_o |

## Verification
A raw SCK rising edge is acted on three system cycles later: two synchroniser stages plus the edge detector. The write strobe appears one cycle after that. MISO settles three cycles after a raw falling edge, and a read word is loaded one cycle after the byte boundary. The bench holds each SCK phase for eight system cycles and samples MISO at the end of the low phase. A monitor records write strobes on falling clock edges, and the bench compares that log only after select has been released, so every due result has arrived before it is checked.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_port_edge.sv
module spi_port_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sck_i;
  end

  assign rise_o = sck_i & ~prev_q;
  assign fall_o = ~sck_i & prev_q;
endmodule

// File: rtl/spi_port_txsr.sv
module spi_port_txsr #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              shift_i,
  output logic              miso_o
);
  logic [DATA_W-1:0] sr_q;
  logic              miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      miso_q <= 1'b0;
    end else if (clear_i) begin
      sr_q   <= '0;
      miso_q <= 1'b0;
    end else if (load_i) begin
      sr_q <= din_i;
    end else if (shift_i) begin
      miso_q <= sr_q[DATA_W-1];
      sr_q   <= {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  assign miso_o = miso_q;

  // R9: output quiet one cycle after select seen high
  a_r9_miso_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !miso_o);
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              mosi_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              load_o
);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int DIR_BIT = DATA_W - 1;
  localparam int INC_BIT = DATA_W - 2;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  phase_e            phase_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sr_q;
  logic              wr_q, inc_q, we_q, adv_q, load_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] next_byte;
  logic              byte_done;

  assign next_byte = {sr_q[DATA_W-2:0], mosi_i};
  assign byte_done = active_i & rise_i & (bit_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      bit_q   <= '0;
      sr_q    <= '0;
      wr_q    <= 1'b0;
      inc_q   <= 1'b0;
      we_q    <= 1'b0;
      adv_q   <= 1'b0;
      load_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      we_q   <= 1'b0;
      adv_q  <= 1'b0;
      load_q <= 1'b0;
      if (adv_q) addr_q <= addr_q + 1'b1;
      if (!active_i) begin
        // partial byte dropped here
        phase_q <= PH_CMD;
        bit_q   <= '0;
      end else if (rise_i) begin
        sr_q  <= next_byte;
        bit_q <= byte_done ? '0 : bit_q + 1'b1;
        if (byte_done) begin
          if (phase_q == PH_CMD) begin
            wr_q    <= next_byte[DIR_BIT];
            inc_q   <= next_byte[INC_BIT];
            addr_q  <= next_byte[ADDR_W-1:0];
            phase_q <= PH_DATA;
            load_q  <= ~next_byte[DIR_BIT];
          end else if (wr_q) begin
            we_q    <= 1'b1;
            wdata_q <= next_byte;
            adv_q   <= inc_q;   // step after the strobe cycle
          end else begin
            if (inc_q) addr_q <= addr_q + 1'b1;
            load_q <= 1'b1;
          end
        end
      end
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign we_o    = we_q;
  assign load_o  = load_q;

  a_r3_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);

  a_r11_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (wr_q && phase_q == PH_DATA));

  a_r8_full_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> ($past(bit_q) == LAST_BIT));

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_q == PH_DATA) && $past(inc_q) && addr_q != $past(addr_q))
      |-> (addr_q == $past(addr_q) + ADDR_W'(1)));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_q == PH_DATA) && phase_q == PH_DATA && !inc_q) |-> $stable(addr_q));
endmodule

// File: rtl/spi_burst_port.sv
module spi_burst_port #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic              miso_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic [2:0] raw, synced;
  logic       sck_s, mosi_s, ss_s;
  logic       rise, fall, active, load;

  assign raw = {ss_ni, mosi_i, sck_i};
  assign {ss_s, mosi_s, sck_s} = synced;
  assign active = ~ss_s;

  spi_port_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  spi_port_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sck_i (sck_s),
    .rise_o(rise),
    .fall_o(fall)
  );

  spi_port_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .rise_i  (rise),
    .mosi_i  (mosi_s),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o),
    .we_o    (reg_we_o),
    .load_o  (load)
  );

  spi_port_txsr #(
    .DATA_W(DATA_W)
  ) u_txsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(~active),
    .load_i (load),
    .din_i  (reg_rdata_i),
    .shift_i(fall & active),
    .miso_o (miso_o)
  );
endmodule

// File: tb/sim_spi_burst_port.sv
`timescale 1ns/1ps
module sim_spi_burst_port;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic       miso_o;
  logic [5:0] reg_addr_o;
  logic [7:0] reg_wdata_o;
  logic       reg_we_o;
  logic [7:0] reg_rdata_i;

  logic [7:0] mem [64];
  logic [7:0] expv [64];
  int         log_addr [256];
  int         log_data [256];
  int         log_n = 0;
  int         wide_we = 0;
  logic       prev_we = 1'b0;
  logic [7:0] tx_buf [80];
  logic [7:0] rx_buf [80];
  logic [7:0] cmd_rx;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  spi_burst_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_ni(ss_n),
    .miso_o(miso_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_we_o(reg_we_o), .reg_rdata_i(reg_rdata_i)
  );

  assign reg_rdata_i = mem[reg_addr_o];

  always @(negedge clk) begin
    if (reg_we_o) begin
      mem[reg_addr_o] <= reg_wdata_o;
      if (log_n < 256) begin
        log_addr[log_n] = reg_addr_o;
        log_data[log_n] = reg_wdata_o;
      end
      log_n = log_n + 1;
    end
    if (reg_we_o && prev_we) wide_we = wide_we + 1;
    prev_we = reg_we_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic shift_byte(input logic [7:0] b, input int nbits, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk) mosi = b[i];
      repeat (HALF - 1) @(negedge clk);
      r[i] = miso_o;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nbytes, input int tail_bits);
    logic [7:0] r;
    log_n = 0;
    @(negedge clk) ss_n = 1'b0;
    repeat (4) @(negedge clk);
    shift_byte(cmd, 8, r);
    cmd_rx = r;
    for (int k = 0; k < nbytes; k++) begin
      shift_byte(tx_buf[k], 8, r);
      rx_buf[k] = r;
    end
    if (tail_bits > 0) shift_byte(8'hFF, tail_bits, r);
    repeat (6) @(negedge clk);
    ss_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < 64; a++) begin mem[a] = '0; expv[a] = '0; end
    repeat (3) @(negedge clk);
    chk("R10 miso", miso_o, 0);
    chk("R10 we", reg_we_o, 0);
    chk("R10 addr", reg_addr_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // full write burst, increment, from 0
    for (int a = 0; a < 64; a++) tx_buf[a] = pat(a);
    xfer(8'hC0, 64, 0);
    chk("R7 burst strobe count", log_n, 64);
    for (int a = 0; a < 64; a++) begin
      chk("R1/R4 write addr", log_addr[a], a);
      chk("R3 write data", log_data[a], pat(a));
      expv[a] = pat(a);
    end
    chk("R9 miso in write", cmd_rx, 0);

    // read burst with wrap
    for (int k = 0; k < 66; k++) tx_buf[k] = 8'h00;
    xfer(8'h40, 66, 0);
    chk("R11 no strobe in read", log_n, 0);
    chk("R9 miso during command", cmd_rx, 0);
    for (int k = 0; k < 66; k++) chk("R2/R6 read burst", rx_buf[k], expv[k % 64]);

    // single reads
    for (int a = 0; a < 64; a++) begin
      xfer(8'(a), 1, 0);
      chk("R6 single read", rx_buf[0], expv[a]);
      chk("R9 command quiet", cmd_rx, 0);
    end

    // wrap write
    for (int k = 0; k < 4; k++) tx_buf[k] = 8'hC0 + 8'(k);
    xfer(8'hC0 | 8'd62, 4, 0);
    chk("R4 wrap count", log_n, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R4 wrap addr", log_addr[k], (62 + k) % 64);
      chk("R4 wrap data", log_data[k], 8'hC0 + k);
      expv[(62 + k) % 64] = 8'hC0 + 8'(k);
    end

    // fixed-address write
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
    xfer(8'h80 | 8'd10, 3, 0);
    chk("R5 fixed count", log_n, 3);
    for (int k = 0; k < 3; k++) chk("R5 fixed addr", log_addr[k], 10);
    expv[10] = 8'h33;
    xfer(8'd10, 3, 0);
    for (int k = 0; k < 3; k++) chk("R5/R6 fixed read", rx_buf[k], 8'h33);

    // read from 63 with wrap
    xfer(8'h40 | 8'd63, 3, 0);
    chk("R4 read wrap 63", rx_buf[0], expv[63]);
    chk("R4 read wrap 0", rx_buf[1], expv[0]);
    chk("R4 read wrap 1", rx_buf[2], expv[1]);

    // partial trailing byte
    tx_buf[0] = 8'h5A;
    xfer(8'hC0 | 8'd20, 1, 5);
    chk("R8 strobes", log_n, 1);
    chk("R8 addr", log_addr[0], 20);
    chk("R8 data", log_data[0], 8'h5A);
    expv[20] = 8'h5A;
    xfer(8'h40 | 8'd20, 2, 0);
    chk("R7/R8 readback 20", rx_buf[0], 8'h5A);
    chk("R8 neighbour untouched", rx_buf[1], expv[21]);

    // idle MISO
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R9 idle miso", miso_o, 0);
    end
    chk("R3 strobe width", wide_we, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule